// File: doc/BRIEF.md
# Multi-Mode Reloadable Down-Counting Timer

This block is a parameterised down-counter, 12 bits wide by default, that has a separate reload register. One counter serves four modes, chosen by a two-bit mode input.

- **Interval timer:** the counter steps on each prescaler tick.
- **Square wave:** the counter steps on each prescaler tick, and an output pin toggles every time the counter reloads.
- **Event counter:** the counter steps on each rising edge of an external pin.
- **Pulse width:** the counter steps on prescaler ticks only while the external pin is high, and it reports when the pulse ends.

The external pin is asynchronous, so it passes through a two-flop synchroniser before it is used.

The CPU side has four one-cycle commands: write the reload value, start, stop, and a continuous read of the live count. When a step arrives with the counter at zero, the counter takes the reload value again and raises a one-cycle interrupt request. The prescaler is outside the block and arrives as a single-cycle enable, `tick`.

Top module: `mtimer12`

## Requirements
- R1: After synchronous reset, the timer is stopped and `cnt_q`, the reload value, `irq`, `sq_out` and `pw_done` are all 0.
- R2: `cmd_wr` stores `wr_data` in the reload register only. It never changes `cnt_q` directly.
- R3: `cnt_q` always shows the live counter. A step with a non-zero count lowers it by exactly 1, one clock after the step condition is seen.
- R4: A step with the count at 0 loads the reload value that was held before that edge. `irq` is then high for that one following cycle.
- R5: In mode 0 (interval), while running, every cycle with `tick` high is a step. With `tick` high on every cycle, two `irq` pulses are reload+1 cycles apart. With `tick` high on every other cycle, they are 2*(reload+1) cycles apart.
- R6: Mode 3 (square wave) steps as mode 0 does. `sq_out` inverts on each reload and holds at all other times.
- R7: In mode 1 (event), `ext_in` passes through two flops. Each rising edge of the synchronised level is one step, and `tick` is ignored. A level change of `ext_in` is seen by the counter three edges after it is sampled.
- R8: In mode 2 (pulse width), a step is `tick` while the synchronised input is high. After a synchronised falling edge, while the timer is running in mode 2, `pw_done` pulses for one cycle.
- R9: `cmd_start` and `cmd_stop` take effect from the next cycle, and stop wins if both are given together. Stopping freezes the count. Starting again resumes from the frozen value without a reload.
- R10: If `cmd_wr` arrives in the same cycle as a reload, the counter takes the old reload value, and the new value is used from the next reload onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Prescaler enable, one cycle wide |
| mode | input | 2 | 0 interval, 1 event, 2 pulse width, 3 square wave |
| ext_in | input | 1 | Asynchronous event/gate pin |
| cmd_wr | input | 1 | Write the reload register |
| wr_data | input | 12 | Reload value |
| cmd_start | input | 1 | Start counting |
| cmd_stop | input | 1 | Stop counting |
| cnt_q | output | 12 | Live counter value |
| irq | output | 1 | One-cycle pulse after each reload |
| sq_out | output | 1 | Square-wave pin |
| pw_done | output | 1 | One-cycle pulse when a measured pulse ends |

## Verification
The bench targets the wrap from zero, reload writes that land in the same cycle as a reload, and stop-then-start sequences.

- A design that decremented below zero would put 4095 on `cnt_q` instead of the reload value.
- A design that reloaded on start would lose the frozen count.
- A design that let a write reach the live counter would shorten the period in progress.

In event and pulse-width modes, the bench keeps `tick` active to show that it is ignored or gated. It also times the input against the three-edge synchroniser latency, so a missing or extra flop shifts every step by a cycle. A design that missed the stop-wins priority, or produced a two-cycle `pw_done`, would disagree with the cycle-level model on the affected cycle.

// File: rtl/mtimer12_pkg.sv
package mtimer12_pkg;
    // Counting modes; the encoding is visible at the mode port.
    typedef enum logic [1:0] {
        MODE_INTERVAL = 2'd0,
        MODE_EVENT    = 2'd1,
        MODE_PULSE    = 2'd2,
        MODE_SQUARE   = 2'd3
    } tmr_mode_e;
endpackage

// File: rtl/tmr_sync.sv
// Synchroniser with edge detection for an asynchronous pin.
// STAGES flops resolve metastability. One extra flop holds the previous
// synchronised level, so that rising and falling edges can be decoded.
// Assumes the pin stays stable for at least one clock per level.
module tmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain;

    // Shift the pin value along the chain; the last bit is the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], async_in};
    end

    // Decode the synchronised level and its edges.
    always_comb begin
        level = chain[STAGES-1];
        rise  = chain[STAGES-1] & ~chain[STAGES];
        fall  = ~chain[STAGES-1] & chain[STAGES];
    end
endmodule

// File: rtl/tmr_step_sel.sv
// Chooses which event counts as one counter step, based on the mode.
// This block is purely combinational. Run gating is applied by the
// counter core.
module tmr_step_sel
    import mtimer12_pkg::*;
(
    input  tmr_mode_e mode,
    input  logic      tick,
    input  logic      level,
    input  logic      rise,
    output logic      step
);
    // Pick the step source for each mode.
    always_comb begin
        unique case (mode)
            MODE_EVENT:  step = rise;
            MODE_PULSE:  step = tick & level;
            default:     step = tick;
        endcase
    end
endmodule

// File: rtl/tmr_core.sv
// Reloadable down-counter with run control, reload interrupt,
// square-wave toggle and pulse-end flag.
// Assumes the incoming step has already been qualified by mode. Run
// gating is applied here.
module tmr_core #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         square_en,
    input  logic         pulse_en,
    input  logic         fall,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic         start,
    input  logic         stop,
    output logic [W-1:0] cnt,
    output logic [W-1:0] reload,
    output logic         run,
    output logic         irq,
    output logic         sq,
    output logic         pw_done
);
    logic go;
    logic at_zero;

    // Qualify the step with the run state and detect the wrap point.
    always_comb begin
        go      = run & step;
        at_zero = (cnt == '0);
    end

    // Counter: decrement on a step, or reload when it is already at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (go && at_zero)  cnt <= reload;
        else if (go)             cnt <= cnt - 1'b1;
    end

    // Reload register, written only by the CPU write command.
    always_ff @(posedge clk) begin
        if (!rst_n)  reload <= '0;
        else if (wr) reload <= wr_data;
    end

    // Run flag; stop has priority over start.
    always_ff @(posedge clk) begin
        if (!rst_n)     run <= 1'b0;
        else if (stop)  run <= 1'b0;
        else if (start) run <= 1'b1;
    end

    // One-cycle interrupt request after each reload.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= go & at_zero;
    end

    // Square-wave pin toggles on each reload in square mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                        sq <= 1'b0;
        else if (go && at_zero && square_en) sq <= ~sq;
    end

    // Pulse-end flag on a synchronised falling edge while measuring.
    always_ff @(posedge clk) begin
        if (!rst_n) pw_done <= 1'b0;
        else        pw_done <= run & pulse_en & fall;
    end
endmodule

// File: rtl/mtimer12.sv
// Top level of the multi-mode reloadable timer.
// Connects the pin synchroniser, the step selector and the counter core.
// Assumes the commands are single-cycle pulses from a CPU-side decoder
// and that `tick` is a one-cycle prescaler enable.
module mtimer12
    import mtimer12_pkg::*;
#(
    parameter int W           = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [1:0]   mode,
    input  logic         ext_in,
    input  logic         cmd_wr,
    input  logic [W-1:0] wr_data,
    input  logic         cmd_start,
    input  logic         cmd_stop,
    output logic [W-1:0] cnt_q,
    output logic         irq,
    output logic         sq_out,
    output logic         pw_done
);
    tmr_mode_e    mode_e;
    logic         ext_lvl, ext_rise, ext_fall;
    logic         step;
    logic [W-1:0] reload_q;
    logic         run_q;

    // Convert the raw mode bits to the enumerated type.
    always_comb mode_e = tmr_mode_e'(mode);

    tmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_in),
        .level    (ext_lvl),
        .rise     (ext_rise),
        .fall     (ext_fall)
    );

    tmr_step_sel u_sel (
        .mode  (mode_e),
        .tick  (tick),
        .level (ext_lvl),
        .rise  (ext_rise),
        .step  (step)
    );

    tmr_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .square_en (mode_e == MODE_SQUARE),
        .pulse_en  (mode_e == MODE_PULSE),
        .fall      (ext_fall),
        .wr        (cmd_wr),
        .wr_data   (wr_data),
        .start     (cmd_start),
        .stop      (cmd_stop),
        .cnt       (cnt_q),
        .reload    (reload_q),
        .run       (run_q),
        .irq       (irq),
        .sq        (sq_out),
        .pw_done   (pw_done)
    );
endmodule

// File: rtl/mtimer12_chk.sv
// Property checker for mtimer12, attached to it with a bind statement.
module mtimer12_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] cnt_q,
    input logic         irq,
    input logic         sq_out,
    input logic         pw_done,
    input logic [W-1:0] reload_q,
    input logic         run_q
);
    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> $stable(cnt_q));

    p_irq_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cnt_q == $past(reload_q)));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_q) |-> (irq || (cnt_q == $past(cnt_q) - 1'b1)));

    p_sq_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sq_out) |-> irq);

    p_pw_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pw_done |=> !pw_done);
endmodule

bind mtimer12 mtimer12_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_q    (cnt_q),
    .irq      (irq),
    .sq_out   (sq_out),
    .pw_done  (pw_done),
    .reload_q (reload_q),
    .run_q    (run_q)
);

// File: tb/sim_mtimer12.sv
`timescale 1ns/1ps
module sim_mtimer12;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic [1:0]   mode = 2'd0;
    logic         ext_in = 1'b0;
    logic         cmd_wr = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         cmd_start = 1'b0;
    logic         cmd_stop = 1'b0;
    logic [W-1:0] cnt_q;
    logic         irq, sq_out, pw_done;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int tick_pat = 0;
    int irq_n = 0, sqt_n = 0, pwd_n = 0;
    int rel_sw = 0;
    bit prev_sq = 0;

    // Reference model state.
    int m_cnt = 0, m_rel = 0, m_run = 0, m_irq = 0, m_sq = 0, m_pwd = 0;
    bit hist[$] = '{0, 0, 0};

    always #4 clk = ~clk;

    mtimer12 u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .ext_in(ext_in),
        .cmd_wr(cmd_wr), .wr_data(wr_data), .cmd_start(cmd_start),
        .cmd_stop(cmd_stop), .cnt_q(cnt_q), .irq(irq), .sq_out(sq_out),
        .pw_done(pw_done)
    );

    // Drive the prescaler tick from a pattern selector.
    always @(negedge clk) begin
        case (tick_pat)
            1: tick <= 1'b1;
            2: tick <= ~tick;
            3: tick <= ($urandom_range(0, 2) == 0);
            default: tick <= 1'b0;
        endcase
    end

    // Behavioural model, advanced on every clock edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_rel = 0; m_run = 0; m_irq = 0; m_sq = 0; m_pwd = 0;
            hist = '{0, 0, 0};
        end else begin
            bit lvl, prv, stp;
            lvl = hist[1];
            prv = hist[2];
            case (mode)
                2'd1:    stp = lvl && !prv;
                2'd2:    stp = tick && lvl;
                default: stp = tick;
            endcase
            m_irq = 0;
            if (m_run != 0 && stp) begin
                if (m_cnt == 0) begin
                    m_cnt = m_rel;
                    m_irq = 1;
                    if (mode == 2'd3) m_sq = 1 - m_sq;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
            m_pwd = (m_run != 0 && mode == 2'd2 && !lvl && prv) ? 1 : 0;
            if (cmd_wr) m_rel = int'(wr_data);
            if (cmd_stop)       m_run = 0;
            else if (cmd_start) m_run = 1;
            hist.push_front(ext_in);
            void'(hist.pop_back());
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Compare every output with the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(cnt_q) == m_cnt, "R2 R3 R9 R10 cnt_q", int'(cnt_q), m_cnt);
            chk(int'(irq) == m_irq, "R4 irq", int'(irq), m_irq);
            chk(int'(sq_out) == m_sq, "R6 sq_out", int'(sq_out), m_sq);
            chk(int'(pw_done) == m_pwd, "R8 pw_done", int'(pw_done), m_pwd);
            if (irq) irq_n++;
            if (pw_done) pwd_n++;
            if (sq_out != prev_sq) sqt_n++;
        end
        prev_sq = sq_out;
    end

    // Number of counter steps applied to value v, using the reload value r.
    function automatic int adv(input int v, input int n, input int r);
        int x = v;
        for (int i = 0; i < n; i++) x = (x == 0) ? r : x - 1;
        return x;
    endfunction

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_cmd(input int which);
        @(negedge clk);
        if (which == 0) cmd_start = 1'b1; else cmd_stop = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0; cmd_stop = 1'b0;
    endtask

    task automatic write_rel(input int v);
        @(negedge clk);
        cmd_wr = 1'b1; wr_data = W'(v); rel_sw = v;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wait_irq(output int c);
        int k = 0;
        @(negedge clk);
        while (!irq && k < 1000) begin @(negedge clk); k++; end
        c = cyc;
    endtask

    // Watchdog: an expired run counts as one failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c1, c2, v;
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(cnt_q == 0, "R1 reset cnt_q", int'(cnt_q), 0);
        chk(irq == 0 && sq_out == 0 && pw_done == 0, "R1 reset flags",
            int'({irq, sq_out, pw_done}), 0);
        rst_n = 1'b1;
        // R2: a write while stopped leaves the counter untouched.
        write_rel(5);
        cycles(2);
        chk(cnt_q == 0, "R2 write keeps cnt_q", int'(cnt_q), 0);
        // R5: interval period with tick on every cycle.
        mode = 2'd0; tick_pat = 1;
        pulse_cmd(0);
        wait_irq(c1); wait_irq(c2);
        chk(c2 - c1 == 6, "R5 period tick every cycle", c2 - c1, 6);
        tick_pat = 2;
        wait_irq(c1); wait_irq(c1); wait_irq(c2);
        chk(c2 - c1 == 12, "R5 period tick alternate", c2 - c1, 12);
        // R9: stop freezes, start resumes without a reload.
        tick_pat = 1;
        write_rel(40);
        wait_irq(c1);
        cycles(3);
        pulse_cmd(1);
        cycles(1);
        v = int'(cnt_q);
        cycles(6);
        chk(int'(cnt_q) == v, "R9 frozen while stopped", int'(cnt_q), v);
        pulse_cmd(0);
        cycles(1);
        chk(int'(cnt_q) == adv(v, 1, rel_sw), "R9 resume no reload",
            int'(cnt_q), adv(v, 1, rel_sw));
        // R9: stop wins over start given together.
        @(negedge clk); cmd_start = 1'b1; cmd_stop = 1'b1;
        @(negedge clk); cmd_start = 1'b0; cmd_stop = 1'b0;
        cycles(1);
        v = int'(cnt_q);
        cycles(4);
        chk(int'(cnt_q) == v, "R9 stop priority", int'(cnt_q), v);
        // R6: square-wave toggles match reloads.
        write_rel(3);
        mode = 2'd3;
        pulse_cmd(0);
        cycles(2);
        irq_n = 0; sqt_n = 0;
        cycles(40);
        chk(sqt_n == irq_n && irq_n > 0, "R6 toggles per reload", sqt_n, irq_n);
        // R7: event mode ignores ticks and counts synchronised rising edges.
        pulse_cmd(1);
        write_rel(100);
        mode = 2'd1; ext_in = 1'b0;
        cycles(4);
        pulse_cmd(0);
        cycles(1);
        v = int'(cnt_q);
        cycles(10);
        chk(int'(cnt_q) == v, "R7 ticks ignored", int'(cnt_q), v);
        for (int i = 0; i < 3; i++) begin
            ext_in = 1'b1; cycles(2);
            ext_in = 1'b0; cycles(2);
        end
        cycles(4);
        chk(int'(cnt_q) == adv(v, 3, rel_sw), "R7 three edges",
            int'(cnt_q), adv(v, 3, rel_sw));
        // R8: pulse-width mode counts ticks while high and flags the end.
        pulse_cmd(1);
        mode = 2'd2;
        cycles(4);
        pulse_cmd(0);
        cycles(1);
        v = int'(cnt_q);
        pwd_n = 0;
        ext_in = 1'b1; cycles(8);
        ext_in = 1'b0; cycles(6);
        chk(int'(cnt_q) == adv(v, 8, rel_sw), "R8 gated count",
            int'(cnt_q), adv(v, 8, rel_sw));
        chk(pwd_n == 1, "R8 one pw_done pulse", pwd_n, 1);
        // R10 and general: random stimulus against the model.
        tick_pat = 3;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            ext_in    = ($urandom_range(0, 5) == 0) ? ~ext_in : ext_in;
            cmd_wr    = ($urandom_range(0, 9) == 0);
            wr_data   = W'($urandom_range(0, 7));
            cmd_start = ($urandom_range(0, 15) == 0);
            cmd_stop  = ($urandom_range(0, 40) == 0);
            if ($urandom_range(0, 99) == 0) mode = 2'($urandom_range(0, 3));
        end
        @(negedge clk);
        cmd_wr = 1'b0; cmd_start = 1'b0; cmd_stop = 1'b0;
        cycles(3);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule